// File: doc/BRIEF.md
# Critical Interrupt Entry Controller

This block decides, cycle by cycle, whether a processor enters its critical-input interrupt or its machine-check interrupt, and produces what that entry needs. It forms the 32-bit handler address and the updated status word, and it captures the return PC and the prior status into the critical save registers. It also accumulates machine-check causes in a syndrome register. A machine-check source that appears while machine checks are disabled drives the block into a sticky checkstop.

The handler address is the 16-bit vector prefix, then a 12-bit offset, then four zero bits. For a critical input the offset comes from offset register 0 when the autovector strobe is asserted. Otherwise it comes from the external offset pins. A machine check always uses offset register 1. The core presents its current status word every cycle. Whenever a vector is issued, the block returns the new status word alongside it, one cycle after the request is sampled.

Top module: `crit_entry_ctrl`

## Requirements
- R1: With `crit_req_n` low, status bit 17 (critical enable) set and `avec_n` low, the next cycle shows `vec_valid`=1, `vec_is_mc`=0 and `vec_addr` = {`ivpr_hi`, `ivor0_off`, 4'b0000}.
- R2: With `avec_n` high while `crit_req_n` is low, `ext_voff` replaces `ivor0_off` in the address.
- R3: A critical request is ignored while status bit 17 is 0. No vector is issued and the save registers keep their values.
- R4: Critical entry writes `cur_pc` to `csrr0` and `msr_cur` to `csrr1` in the cycle the vector appears. In `msr_nxt`, bits 17 and 1 (recoverable) are cleared and every bit except bit 9 keeps its value from `msr_cur`.
- R5: On critical entry, status bit 9 (debug enable) is cleared when `dbg_unit_en` is 0 or `cfg_ci_clr_de` is 1. Otherwise it is kept.
- R6: Any bit of `mc_src` with status bit 12 (machine-check enable) set gives `vec_is_mc`=1 the next cycle, with the offset from `ivor1_off`. Bits 17, 12 and 1 are cleared, and bit 9 is cleared only if `cfg_mc_clr_de` is 1. The save registers are left unchanged.
- R7: A machine check and a critical request in the same cycle produce a machine-check vector only.
- R8: `mcsr` ORs in `mc_src` on each machine check taken and clears bits written one on `mcsr_clr`, with a new cause winning over a clear. Critical entry leaves it unchanged.
- R9: A machine-check source while bit 12 is 0 sets `checkstop` the next cycle without recording a cause. `checkstop` stays set until reset, and no vector is issued while it is set.
- R10: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| crit_req_n | input | 1 | Critical input request, active low |
| avec_n | input | 1 | Autovector strobe, active low |
| ext_voff | input | 12 | External vector offset |
| mc_src | input | NSRC | Machine-check source lines |
| mcsr_clr | input | NSRC | Write-one-to-clear for the syndrome |
| ivpr_hi | input | 16 | Vector prefix |
| ivor0_off | input | 12 | Critical input offset register |
| ivor1_off | input | 12 | Machine-check offset register |
| dbg_unit_en | input | 1 | Debug unit enabled |
| cfg_ci_clr_de | input | 1 | Clear debug enable on critical input |
| cfg_mc_clr_de | input | 1 | Clear debug enable on machine check |
| cur_pc | input | 32 | PC of the interrupted instruction |
| msr_cur | input | 32 | Current status word |
| vec_valid | output | 1 | Vector issued this cycle |
| vec_is_mc | output | 1 | Issued vector is a machine check |
| vec_addr | output | 32 | Handler address |
| msr_nxt | output | 32 | Status word after entry |
| csrr0 | output | 32 | Saved return PC |
| csrr1 | output | 32 | Saved status word |
| mcsr | output | NSRC | Machine-check syndrome |
| checkstop | output | 1 | Sticky checkstop |

## Verification
A table of requests tries the critical path with the autovector strobe both asserted and negated. This separates the two offset sources by using distinct offset values. The same table covers three debug-unit and configuration combinations that separate cleared from kept debug-enable, and a request with critical enable off. Machine-check rows cover a check alone, and a check together with a critical request to show priority. Directed steps then show that the syndrome accumulates, that a set beats a clear in the same cycle, that checkstop is entered and held, and the reset state.

// File: rtl/crit_entry_ctrl.sv
module crit_entry_ctrl #(
  parameter int NSRC   = 4,
  parameter int CE_BIT = 17,
  parameter int ME_BIT = 12,
  parameter int DE_BIT = 9,
  parameter int RI_BIT = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            crit_req_n,
  input  logic            avec_n,
  input  logic [11:0]     ext_voff,
  input  logic [NSRC-1:0] mc_src,
  input  logic [NSRC-1:0] mcsr_clr,
  input  logic [15:0]     ivpr_hi,
  input  logic [11:0]     ivor0_off,
  input  logic [11:0]     ivor1_off,
  input  logic            dbg_unit_en,
  input  logic            cfg_ci_clr_de,
  input  logic            cfg_mc_clr_de,
  input  logic [31:0]     cur_pc,
  input  logic [31:0]     msr_cur,
  output logic            vec_valid,
  output logic            vec_is_mc,
  output logic [31:0]     vec_addr,
  output logic [31:0]     msr_nxt,
  output logic [31:0]     csrr0,
  output logic [31:0]     csrr1,
  output logic [NSRC-1:0] mcsr,
  output logic            checkstop
);

  logic        mc_hit, mc_take, cs_hit, ci_take;
  logic [11:0] off;
  logic [31:0] msr_upd;

  assign mc_hit  = |mc_src;
  assign mc_take = !checkstop && mc_hit && msr_cur[ME_BIT];
  assign cs_hit  = !checkstop && mc_hit && !msr_cur[ME_BIT];
  assign ci_take = !checkstop && !mc_hit && !crit_req_n && msr_cur[CE_BIT];
  assign off     = mc_take ? ivor1_off : (avec_n ? ext_voff : ivor0_off);

  always_comb begin
    msr_upd         = msr_cur;
    msr_upd[CE_BIT] = 1'b0;
    msr_upd[RI_BIT] = 1'b0;
    if (mc_take) begin
      msr_upd[ME_BIT] = 1'b0;
      if (cfg_mc_clr_de) msr_upd[DE_BIT] = 1'b0;
    end else if (!dbg_unit_en || cfg_ci_clr_de) begin
      msr_upd[DE_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_is_mc <= 1'b0;
      vec_addr  <= '0;
      msr_nxt   <= '0;
      csrr0     <= '0;
      csrr1     <= '0;
      mcsr      <= '0;
      checkstop <= 1'b0;
    end else begin
      vec_valid <= mc_take || ci_take;
      vec_is_mc <= mc_take;
      if (mc_take || ci_take) begin
        vec_addr <= {ivpr_hi, off, 4'b0000};
        msr_nxt  <= msr_upd;
      end
      if (ci_take) begin
        csrr0 <= cur_pc;
        csrr1 <= msr_cur;
      end
      mcsr <= (mcsr & ~mcsr_clr) | (mc_take ? mc_src : '0);
      if (cs_hit) checkstop <= 1'b1;
    end
  end

  AST_CE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!msr_cur[CE_BIT] && !mc_hit) |=> !vec_valid); // R3
  AST_CI_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ci_take |=> (csrr0 == $past(cur_pc)) && (csrr1 == $past(msr_cur))); // R4
  AST_ENTRY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (!msr_nxt[CE_BIT] && !msr_nxt[RI_BIT])); // R4
  AST_DE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_take && dbg_unit_en && !cfg_ci_clr_de) |=> (msr_nxt[DE_BIT] == $past(msr_cur[DE_BIT]))); // R5
  AST_MC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!checkstop && mc_hit && msr_cur[ME_BIT] && !crit_req_n) |=> (vec_valid && vec_is_mc)); // R7
  AST_CHKSTP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop); // R9
  AST_NO_VEC_IN_CHKSTP: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> !vec_valid); // R9

endmodule

// File: tb/crit_entry_ctrl_tb_top.sv
module crit_entry_ctrl_tb_top;
  localparam int NSRC = 4;

  typedef struct packed {
    logic        crit_n;
    logic        avec_n;
    logic [11:0] ext;
    logic [3:0]  mc;
    logic [31:0] msr;
    logic        dbg;
    logic        ciclr;
    logic        mcclr;
    logic        ev;
    logic        emc;
    logic [11:0] eoff;
    logic [31:0] emsr;
  } row_t;

  localparam int NROW = 7;
  localparam row_t TBL [NROW] = '{
    '{1'b0, 1'b0, 12'h000, 4'b0000, 32'h8002_1202, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h120, 32'h8000_1000}, // R1 R5
    '{1'b0, 1'b1, 12'hFED, 4'b0000, 32'h8002_1202, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'hFED, 32'h8000_1200}, // R2 R5
    '{1'b0, 1'b0, 12'h555, 4'b0000, 32'h8002_1202, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 12'h120, 32'h8000_1000}, // R5
    '{1'b0, 1'b0, 12'h000, 4'b0000, 32'h8000_1202, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h0},         // R3
    '{1'b1, 1'b1, 12'h000, 4'b0001, 32'h8002_1202, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h340, 32'h8000_0200}, // R6
    '{1'b0, 1'b0, 12'h000, 4'b0100, 32'h8002_1202, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 12'h340, 32'h8000_0000}, // R7
    '{1'b1, 1'b1, 12'h000, 4'b0000, 32'h8002_1202, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h0}          // R3
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            crit_req_n = 1'b1, avec_n = 1'b1;
  logic [11:0]     ext_voff = '0;
  logic [NSRC-1:0] mc_src = '0, mcsr_clr = '0;
  logic [15:0]     ivpr_hi = 16'hABCD;
  logic [11:0]     ivor0_off = 12'h120, ivor1_off = 12'h340;
  logic            dbg_unit_en = 1'b0, cfg_ci_clr_de = 1'b0, cfg_mc_clr_de = 1'b0;
  logic [31:0]     cur_pc = '0, msr_cur = '0;
  logic            vec_valid, vec_is_mc, checkstop;
  logic [31:0]     vec_addr, msr_nxt, csrr0, csrr1;
  logic [NSRC-1:0] mcsr;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] sv_pc = '0, sv_msr = '0;

  always #5 clk = ~clk;

  crit_entry_ctrl #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .crit_req_n(crit_req_n), .avec_n(avec_n),
    .ext_voff(ext_voff), .mc_src(mc_src), .mcsr_clr(mcsr_clr), .ivpr_hi(ivpr_hi),
    .ivor0_off(ivor0_off), .ivor1_off(ivor1_off), .dbg_unit_en(dbg_unit_en),
    .cfg_ci_clr_de(cfg_ci_clr_de), .cfg_mc_clr_de(cfg_mc_clr_de), .cur_pc(cur_pc),
    .msr_cur(msr_cur), .vec_valid(vec_valid), .vec_is_mc(vec_is_mc), .vec_addr(vec_addr),
    .msr_nxt(msr_nxt), .csrr0(csrr0), .csrr1(csrr1), .mcsr(mcsr), .checkstop(checkstop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    crit_req_n = 1'b1; avec_n = 1'b1; mc_src = '0; mcsr_clr = '0;
  endtask

  function automatic string tag(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 vec_valid", {31'b0, vec_valid}, 32'h0);
    chk("R10 csrr0", csrr0, 32'h0);
    chk("R10 checkstop", {31'b0, checkstop}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      crit_req_n = TBL[i].crit_n; avec_n = TBL[i].avec_n; ext_voff = TBL[i].ext;
      mc_src = TBL[i].mc; msr_cur = TBL[i].msr; dbg_unit_en = TBL[i].dbg;
      cfg_ci_clr_de = TBL[i].ciclr; cfg_mc_clr_de = TBL[i].mcclr;
      cur_pc = 32'h1000_0000 + 32'(i * 16);
      if (TBL[i].ev && !TBL[i].emc) begin sv_pc = cur_pc; sv_msr = TBL[i].msr; end
      @(negedge clk);
      chk({tag(i), " valid"}, {31'b0, vec_valid}, {31'b0, TBL[i].ev});
      if (TBL[i].ev) begin
        chk({tag(i), " is_mc"}, {31'b0, vec_is_mc}, {31'b0, TBL[i].emc});
        chk({tag(i), " addr"}, vec_addr, {16'hABCD, TBL[i].eoff, 4'b0000});
        chk({tag(i), " msr_nxt"}, msr_nxt, TBL[i].emsr);
      end
      chk({tag(i), " R4 csrr0"}, csrr0, sv_pc);
      chk({tag(i), " R4 csrr1"}, csrr1, sv_msr);
    end
    idle();

    // R8: causes 0001 and 0100 accumulated
    @(negedge clk);
    chk("R8 accumulate", {28'b0, mcsr}, 32'h5);
    // R8: set wins over clear of the same bit
    msr_cur = 32'h8002_1202; mc_src = 4'b0001; mcsr_clr = 4'b0001;
    @(negedge clk);
    chk("R8 set wins", {28'b0, mcsr}, 32'h5);
    idle(); mcsr_clr = 4'b0100;
    @(negedge clk);
    chk("R8 w1c", {28'b0, mcsr}, 32'h1);
    idle(); crit_req_n = 1'b0; avec_n = 1'b0; cur_pc = 32'h2000_0040;
    @(negedge clk);
    chk("R8 crit keeps mcsr", {28'b0, mcsr}, 32'h1);
    chk("R4 csrr0 late", csrr0, 32'h2000_0040);

    // R9: machine check while disabled
    idle(); msr_cur = 32'h8002_0202; mc_src = 4'b0010;
    @(negedge clk);
    chk("R9 checkstop set", {31'b0, checkstop}, 32'h1);
    chk("R9 no vector", {31'b0, vec_valid}, 32'h0);
    chk("R9 no cause", {28'b0, mcsr}, 32'h1);
    idle(); crit_req_n = 1'b0; msr_cur = 32'h8002_1202;
    @(negedge clk);
    @(negedge clk);
    chk("R9 held", {31'b0, checkstop}, 32'h1);
    chk("R9 crit blocked", {31'b0, vec_valid}, 32'h0);
    chk("R9 csrr0 kept", csrr0, 32'h2000_0040);

    idle(); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 checkstop cleared", {31'b0, checkstop}, 32'h0);
    chk("R10 mcsr cleared", {28'b0, mcsr}, 32'h0);
    chk("R10 msr_nxt cleared", msr_nxt, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule